// File: doc/BRIEF.md
# PC Card Attribute-Space Access Sequencer

This block produces the strobe timing for a single read or write to the attribute memory space of a 16-bit PC Card or NAND-style socket. A host starts an access with a one-cycle start pulse that carries the address, the write data and a direction flag. The sequencer then runs three phases in order. In the address-setup phase the address is driven. In the command phase the read strobe or the write strobe is held low. In the hold phase the address and the data are kept stable after the strobe rises. When the access is over, the block pulses done, and for a read the captured data is presented.

Phase lengths come from a 32-bit timing word. The host loads it through a write-enable port, and it resets to 0xFCFCFCFC. The card can stretch the command phase by holding its active-low wait line low. That line passes through a two-flop synchronizer before the sequencer looks at it. Timing words that contain a reserved field value are refused: the block reports an error and produces no bus activity.

Top module: `pcc_attr_seq`

## Requirements
- R1: After reset, busy, done and err are low, both strobes are high and the data output enable is low. The timing word holds 0xFCFCFCFC, so a write started straight after reset gives 253 setup cycles, 253 command cycles and 252 hold cycles.
- R2: The setup field is bits 7:0 of the timing word. A setup value S makes the address valid for S+1 cycles before a strobe goes low, so S=0 gives 1 cycle and S=0xFE gives 255 cycles.
- R3: The wait field is bits 15:8 of the timing word. With the card's wait line high, a wait value W holds the strobe low for exactly W+1 cycles.
- R4: The command phase is stretched while the synchronized wait line is low at the point where the programmed command count runs out. If the pin rises during command cycle k, with k at or beyond the programmed length, the strobe stays low for k+2 cycles. A low level on the wait line that ends before the count runs out has no effect.
- R5: The hold field is bits 23:16 of the timing word. A hold value H gives H hold cycles after the strobe rises on a write and H+2 on a read. In the cycle after the last hold cycle, busy is low and done is high for exactly one cycle.
- R6: A write drives only the write strobe, drives the write data on dev_dout, and keeps dev_doe high in every setup, command and hold cycle. A read drives only the read strobe and keeps dev_doe low throughout.
- R7: On a read, req_rdata takes the value that dev_din has in the last command cycle.
- R8: A timing word is refused if its setup field is 0xFF, its wait field is 0x00 or 0xFF, or its hold field is 0x00 or 0xFF. A start with a refused word produces no strobe and keeps busy low, and raises done and err together for one cycle, one cycle after the start.
- R9: A start pulse that arrives while busy is high is ignored. The address, the phase lengths and the number of done pulses of the running access do not change.
- R10: The timing word is sampled when an access starts. A timing write made during an access changes only later accesses. Bits 31:24 of the word do not affect timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 32 | Timing word value |
| req_start | input | 1 | One-cycle access start |
| req_write | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_busy | output | 1 | An access is in progress |
| req_done | output | 1 | One-cycle end-of-access pulse |
| req_err | output | 1 | Refused timing word, given with done |
| req_rdata | output | DATA_W | Captured read data |
| dev_addr | output | ADDR_W | Card address |
| dev_dout | output | DATA_W | Card data out |
| dev_din | input | DATA_W | Card data in |
| dev_doe | output | 1 | Card data output enable |
| dev_noe_n | output | 1 | Active-low read strobe |
| dev_nwe_n | output | 1 | Active-low write strobe |
| dev_nwait_n | input | 1 | Active-low card wait |

## Verification
The hardest case to reach is a command phase stretched by a wait release that arrives through the synchronizer. The bench holds the wait pin low well before the start. It releases the pin on a chosen command cycle while it counts strobe-low cycles, and it expects the strobe to end two cycles later. A second case releases the pin during setup and checks that no stretch occurs. The capture moment is pinned down by changing dev_din so that it holds the expected value only in the final command cycle.

// File: rtl/pcc_attr_pkg.sv
package pcc_attr_pkg;
  localparam int FW = 8;
  localparam int CW = FW + 1;

  typedef logic [FW-1:0] field_t;
  typedef logic [CW-1:0] count_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_CMD, ST_HOLD} phase_e;

  typedef struct packed {
    field_t spare;
    field_t hold;
    field_t wt;
    field_t setup;
  } timing_t;

  function automatic logic timing_bad(timing_t t);
    logic bad;
    bad = (t.setup == '1) || (t.wt == '0) || (t.wt == '1) ||
          (t.hold == '0) || (t.hold == '1);
    return bad && (t.spare == t.spare);
  endfunction

  function automatic count_t setup_load(field_t f);
    return {1'b0, f};
  endfunction

  function automatic count_t cmd_load(field_t f);
    return {1'b0, f};
  endfunction

  function automatic count_t hold_load(field_t f, logic wr);
    return wr ? ({1'b0, f} - count_t'(1)) : ({1'b0, f} + count_t'(1));
  endfunction
endpackage

// File: rtl/pcc_nwait_sync.sv
module pcc_nwait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pcc_timing_reg.sv
module pcc_timing_reg
  import pcc_attr_pkg::*;
#(
  parameter logic [31:0] RESET_VAL = 32'hFCFC_FCFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output timing_t     tim,
  output logic        bad
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tim <= timing_t'(RESET_VAL);
    else if (we) tim <= timing_t'(wdata);
  end

  assign bad = timing_bad(tim);
endmodule

// File: rtl/pcc_phase_ctr.sv
module pcc_phase_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_ctr_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/pcc_attr_seq.sv
module pcc_attr_seq
  import pcc_attr_pkg::*;
#(
  parameter int          ADDR_W      = 26,
  parameter int          DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] TIMING_RST  = 32'hFCFC_FCFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              req_done,
  output logic              req_err,
  output logic [DATA_W-1:0] req_rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  input  logic [DATA_W-1:0] dev_din,
  output logic              dev_doe,
  output logic              dev_noe_n,
  output logic              dev_nwe_n,
  input  logic              dev_nwait_n
);
  timing_t           tim_live;
  logic              tim_bad;
  field_t            wt_q, hold_q;
  phase_e            st;
  logic              wr_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              nwait_ok;
  logic              ctr_zero, ctr_load, ctr_dec;
  count_t            ctr_val;

  pcc_timing_reg #(.RESET_VAL(TIMING_RST)) u_tim (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .tim(tim_live), .bad(tim_bad));

  pcc_nwait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(dev_nwait_n), .sync_o(nwait_ok));

  pcc_phase_ctr #(.W(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
    .dec(ctr_dec), .zero(ctr_zero));

  // Named internal events
  logic accept, accept_ok, accept_bad;
  logic setup_end, cmd_last, cmd_stall, hold_end;

  assign accept     = (st == ST_IDLE) && req_start;
  assign accept_ok  = accept && !tim_bad;
  assign accept_bad = accept && tim_bad;
  assign setup_end  = (st == ST_SETUP) && ctr_zero;
  assign cmd_last   = (st == ST_CMD) && ctr_zero && nwait_ok;
  assign cmd_stall  = (st == ST_CMD) && ctr_zero && !nwait_ok;
  assign hold_end   = (st == ST_HOLD) && ctr_zero;

  always_comb begin
    ctr_load = accept_ok || setup_end || cmd_last;
    if (accept_ok)      ctr_val = setup_load(tim_live.setup);
    else if (setup_end) ctr_val = cmd_load(wt_q);
    else                ctr_val = hold_load(hold_q, wr_q);
    ctr_dec = (st != ST_IDLE) && !ctr_zero && !ctr_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wt_q    <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept_ok) begin
            st      <= ST_SETUP;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wt_q    <= tim_live.wt;
            hold_q  <= tim_live.hold;
          end else if (accept_bad) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_SETUP: if (setup_end) st <= ST_CMD;
        ST_CMD: begin
          if (cmd_last) begin
            st <= ST_HOLD;
            if (!wr_q) rdata_q <= dev_din;
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_busy  = (st != ST_IDLE);
  assign req_done  = done_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;
  assign dev_addr  = addr_q;
  assign dev_dout  = wdata_q;
  assign dev_doe   = wr_q && (st != ST_IDLE);
  assign dev_noe_n = !((st == ST_CMD) && !wr_q);
  assign dev_nwe_n = !((st == ST_CMD) && wr_q);

  p_setup_to_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_end |=> (!dev_noe_n || !dev_nwe_n));
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stall |=> (st == ST_CMD));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !req_busy);
  p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_noe_n |-> (!dev_doe && dev_nwe_n));
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_done);
  p_bad_skips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (!req_busy && dev_noe_n && dev_nwe_n));
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && req_start) |=> $stable(dev_addr));
endmodule

// File: tb/test_pcc_attr_seq.sv
module test_pcc_attr_seq;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic              req_start = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_busy, req_done, req_err;
  logic [DATA_W-1:0] req_rdata;
  logic [ADDR_W-1:0] dev_addr;
  logic [DATA_W-1:0] dev_dout;
  logic [DATA_W-1:0] dev_din = '0;
  logic              dev_doe, dev_noe_n, dev_nwe_n;
  logic              dev_nwait_n = 1'b1;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  pcc_attr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pcc_attr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_busy(req_busy), .req_done(req_done),
    .req_err(req_err), .req_rdata(req_rdata), .dev_addr(dev_addr),
    .dev_dout(dev_dout), .dev_din(dev_din), .dev_doe(dev_doe),
    .dev_noe_n(dev_noe_n), .dev_nwe_n(dev_nwe_n), .dev_nwait_n(dev_nwait_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(!req_busy && !req_done && !req_err, "R1", "idle flags", {req_busy, req_done, req_err}, 0);
    chk(dev_noe_n && dev_nwe_n && !dev_doe, "R1", "pins", {dev_noe_n, dev_nwe_n, dev_doe}, 3'b110);
  endtask

  // Runs one access and measures setup, command and hold lengths.
  task automatic run_access(input logic wr, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] wd, input int es, input int ec,
                            input int eh, input int rel_s, input int rel_c,
                            input int poke, input logic [31:0] poke_cfg,
                            input logic [DATA_W-1:0] din, input string req);
    int s = 0, c = 0, h = 0, n = 0, bad = 0;
    bit seen = 0;
    logic strobe, other;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    dev_din   = ~din;
    @(negedge clk);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    strobe = 1'b0;
    while (!seen && n < 3000) begin
      n++;
      if (req_done) seen = 1;
      else begin
        strobe = wr ? !dev_nwe_n : !dev_noe_n;
        other  = wr ? !dev_noe_n : !dev_nwe_n;
        if (other || dev_addr != a || dev_doe != wr || !req_busy) bad++;
        if (wr && dev_dout != wd) bad++;
        if (strobe) begin
          c++;
          if (h > 0) bad++;
        end else if (c == 0) s++;
        else h++;
      end
      cfg_we = 1'b0;
      req_start = 1'b0;
      req_addr = a;
      if (!seen) begin
        if (poke != 0 && c == 0 && s == poke) begin
          req_start = 1'b1;
          req_addr  = ~a;
          cfg_we    = 1'b1;
          cfg_wdata = poke_cfg;
        end
        if (rel_s != 0 && c == 0 && s == rel_s) dev_nwait_n = 1'b1;
        if (rel_c != 0 && c == rel_c) dev_nwait_n = 1'b1;
        dev_din = (strobe && c == ec) ? din : ~din;
        @(negedge clk);
      end
    end
    chk(seen, req, "done seen", seen, 1);
    chk(s == es, req, "setup cycles", s, es);
    chk(c == ec, req, "command cycles", c, ec);
    chk(h == eh, req, "hold cycles", h, eh);
    chk(bad == 0, "R6", "pin violations", bad, 0);
    chk(!req_err, "R8", "err on valid access", req_err, 0);
    if (!wr) chk(req_rdata == din, "R7", "read data", req_rdata, din);
    @(negedge clk);
    chk(!req_done && !req_busy, "R5", "single done", {req_done, req_busy}, 0);
  endtask

  task automatic run_bad(input logic [31:0] v);
    set_cfg(v);
    req_write = 1'b1;
    @(negedge clk);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(req_done && req_err && !req_busy && dev_noe_n && dev_nwe_n, "R8",
        "refused start", {req_done, req_err, req_busy, dev_noe_n, dev_nwe_n}, 5'b11011);
    @(negedge clk);
    chk(!req_done && !req_err && !req_busy, "R8", "refused after", {req_done, req_err, req_busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R1 default timing word
    run_access(1'b1, 26'h0123456, 16'hA55A, 253, 253, 252, 0, 0, 0, 0, 16'h0, "R1");
    // R2 R3 R5 minimum values
    set_cfg(32'h0001_0100);
    run_access(1'b1, 26'h0000010, 16'h1234, 1, 2, 1, 0, 0, 0, 0, 16'h0, "R2");
    run_access(1'b0, 26'h0000020, 16'h0, 1, 2, 3, 0, 0, 0, 0, 16'hBEEF, "R5");
    // R4 stretched command
    dev_nwait_n = 1'b0;
    set_cfg(32'h0002_0403);
    run_access(1'b0, 26'h0000030, 16'h0, 4, 10, 4, 0, 8, 0, 0, 16'h5AA5, "R4");
    // R4 wait low only during setup has no effect
    dev_nwait_n = 1'b0;
    set_cfg(32'h0002_0406);
    run_access(1'b1, 26'h0000040, 16'h7777, 7, 5, 2, 2, 0, 0, 0, 16'h0, "R4");
    // R3 R2 R5 maximum values
    set_cfg(32'h00FE_FEFE);
    run_access(1'b1, 26'h0000050, 16'h0F0F, 255, 255, 254, 0, 0, 0, 0, 16'h0, "R3");
    run_access(1'b0, 26'h0000060, 16'h0, 255, 255, 256, 0, 0, 0, 0, 16'hC3C3, "R5");
    // R9 start while busy, R10 timing write during access
    set_cfg(32'h0003_0205);
    run_access(1'b1, 26'h0000070, 16'h2468, 6, 3, 3, 0, 0, 2, 32'h0001_0101, 16'h0, "R9");
    run_access(1'b1, 26'h0000080, 16'h1357, 2, 2, 1, 0, 0, 0, 0, 16'h0, "R10");
    // R8 refused timing words
    run_bad(32'h0001_01FF);
    run_bad(32'h0001_0001);
    run_bad(32'h0001_FF01);
    run_bad(32'h0000_0101);
    run_bad(32'h00FF_0101);
    // R10 upper byte has no effect
    set_cfg(32'hAB01_0100);
    run_access(1'b1, 26'h0000090, 16'h9999, 1, 2, 1, 0, 0, 0, 0, 16'h0, "R10");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule